// File: doc/BRIEF.md
# Multiprocessor Interval Timer Bank

A register-mapped timer unit for a small shared-memory multiprocessor. It contains one private timer per processor plus one shared master timer. Every timer owns a limit register and a running counter. The counter field steps on each clock cycle in which the tick-enable input is high, for example from a one-microsecond strobe. When the next count would equal the limit, the counter returns to 1 rather than to 0, and the timer raises its limit flag. A period of P ticks therefore needs a limit of P+1.

Each private timer drives a level-14 interrupt line to its own processor only. The master timer drives a level-10 line that is copied to every processor. Software reads and writes all timers through a simple select/write/address bus with registered read data. A limit can be written in two ways: the normal address also restarts the counter and clears the flag, and a second address replaces the limit while the counter keeps running. Reading the limit register returns the flag and then clears it. The flag is the timer's interrupt, so this read acknowledges the interrupt.

Top module: `mpt_timer_bank`

## Requirements
- R1: While a timer runs and its limit field is nonzero, a tick whose incremented count equals the limit loads the counter with 1 and sets the flag. The period is therefore limit-1 ticks, and the counter field never holds 0.
- R2: Limit and count read words put the flag in bit 31 and the field in bits FLD_LSB+CNT_W-1:FLD_LSB (30:10 by default). All other bits read as 0. Writes take the field from the same bit positions.
- R3: A write to window offset 0x0 loads the limit, sets the counter to 1 and clears the flag, so the interrupt drops on the next edge.
- R4: A write to window offset 0x8 loads the limit and leaves both the counter and the flag unchanged.
- R5: The flag of processor timer i drives only irq_cpu_l14[i]. The master flag drives every bit of irq_bcast_l10.
- R6: After reset each processor limit field holds PCPU_RST_LIM, so the limit word reads 0x009C4000 with the default parameters. The master limit is MST_RST_LIM (0), every counter is 1, every flag is 0 and every run bit is 1.
- R7: A read of offset 0x0 returns the limit word, then clears that timer's flag unless a hit happens in the same cycle. A read of offset 0x4 changes nothing.
- R8: With a limit field of 0 the counter free-runs from its maximum value back to 1 and never sets the flag.
- R9: A counter advances only on cycles with tick_en high and its run bit (bit 0 of offset 0xC) set. The run bit reads back in bit 0 of offset 0xC.
- R10: Timer window w sits at byte address w*16. Processor timers occupy windows 0..NCPU-1 and the master timer occupies window NCPU. Read data appears on bus_rdata one clock after the read is selected. Offset 0x8 and windows above NCPU read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe; counters advance on cycles where it is high |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (window in the upper bits, register in bits 3:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_cpu_l14 | output | NCPU | Private level-14 interrupt per processor |
| irq_bcast_l10 | output | NCPU | Master level-10 interrupt, copied to each processor |

## Verification
Every write and every tick takes effect at the next rising edge, and a flag reaches its interrupt pin in that same cycle. Read data is registered, so it appears one edge after the select. The bench drives all inputs on the falling edge. It holds each access for exactly one rising edge and samples on the following falling edge, when the counter, flag, interrupt and read data for that edge have all settled. Tick bursts are counted in whole rising edges, so each expected count is the last written value plus the number of ticks, with the wrap rule applied arithmetically.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

   // register slot inside a 16-byte timer window (bus_addr[3:2])
   typedef enum logic [1:0] {
      REG_LIM  = 2'd0,
      REG_CNT  = 2'd1,
      REG_LNC  = 2'd2,
      REG_CTL  = 2'd3
   } mpt_reg_e;

   // per-timer strobes produced by the address decoder
   typedef struct packed {
      logic ld_clr;   // limit write that restarts the counter
      logic ld_keep;  // limit write that leaves the counter running
      logic ctl_wr;   // control write
      logic lim_rd;   // limit read (flag acknowledge)
   } mpt_cmd_t;

endpackage

// File: rtl/mpt_decode.sv
module mpt_decode
   import mpt_pkg::*;
#(
   parameter int NWIN   = 5,
   parameter int ADDR_W = 7
) (
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   output mpt_cmd_t [NWIN-1:0]  cmd_o,
   output logic [ADDR_W-5:0]    rd_win,
   output mpt_reg_e             rd_reg
);
   localparam int WIN_W = ADDR_W - 4;

   logic [WIN_W-1:0] win;
   mpt_reg_e         slot;
   logic             unused_lo;

   assign win       = bus_addr[ADDR_W-1:4];
   assign slot      = mpt_reg_e'(bus_addr[3:2]);
   assign unused_lo = ^bus_addr[1:0];
   assign rd_win    = win;
   assign rd_reg    = slot;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      logic here;
      assign here              = bus_sel && (win == WIN_W'(w));
      assign cmd_o[w].ld_clr   = here &&  bus_wr && (slot == REG_LIM);
      assign cmd_o[w].ld_keep  = here &&  bus_wr && (slot == REG_LNC);
      assign cmd_o[w].ctl_wr   = here &&  bus_wr && (slot == REG_CTL);
      assign cmd_o[w].lim_rd   = here && !bus_wr && (slot == REG_LIM);
   end

endmodule

// File: rtl/mpt_counter.sv
module mpt_counter
   import mpt_pkg::*;
#(
   parameter int               CNT_W   = 21,
   parameter logic [CNT_W-1:0] RST_LIM = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  mpt_cmd_t         cmd,
   input  logic [CNT_W-1:0] wfield,
   input  logic             wrun,
   output logic             flag,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] lim,
   output logic             run
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             adv;
   logic             at_max;
   logic             hit;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_nxt;

   assign adv     = tick_en && run;
   assign cnt_inc = cnt + ONE;
   assign at_max  = &cnt;
   assign hit     = adv && (lim != '0) && (cnt_inc == lim);
   assign cnt_nxt = (hit || at_max) ? ONE : cnt_inc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= ONE;
         lim  <= RST_LIM;
         flag <= 1'b0;
         run  <= 1'b1;
      end else begin
         if (cmd.ctl_wr) run <= wrun;
         if (cmd.ld_clr) begin
            lim  <= wfield;
            cnt  <= ONE;
            flag <= 1'b0;
         end else begin
            if (cmd.ld_keep) lim <= wfield;
            if (adv)         cnt <= cnt_nxt;
            if (hit)              flag <= 1'b1;
            else if (cmd.lim_rd)  flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mpt_timer_bank.sv
module mpt_timer_bank
   import mpt_pkg::*;
#(
   parameter int NCPU         = 4,
   parameter int CNT_W        = 21,
   parameter int FLD_LSB      = 10,
   parameter int PCPU_RST_LIM = 10000,
   parameter int MST_RST_LIM  = 0,
   localparam int NWIN        = NCPU + 1,
   localparam int ADDR_W      = $clog2(NWIN * 16)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCPU-1:0]   irq_cpu_l14,
   output logic [NCPU-1:0]   irq_bcast_l10
);
   localparam int WIN_W = ADDR_W - 4;

   // elaboration-time parameter checks
   if (NCPU < 1) begin : g_bad_ncpu
      $error("mpt_timer_bank: NCPU must be at least 1");
   end
   if (CNT_W < 2 || FLD_LSB < 0 || FLD_LSB + CNT_W > 31) begin : g_bad_field
      $error("mpt_timer_bank: counter field must fit below bit 31");
   end
   if (PCPU_RST_LIM < 0 || PCPU_RST_LIM >= (1 << CNT_W) ||
       MST_RST_LIM  < 0 || MST_RST_LIM  >= (1 << CNT_W)) begin : g_bad_rst
      $error("mpt_timer_bank: reset limit exceeds counter field");
   end

   mpt_cmd_t [NWIN-1:0]             cmd_v;
   logic     [WIN_W-1:0]            rd_win;
   mpt_reg_e                        rd_reg;
   logic     [NWIN-1:0]             flag_v;
   logic     [NWIN-1:0]             run_v;
   logic     [NWIN-1:0][CNT_W-1:0]  cnt_v;
   logic     [NWIN-1:0][CNT_W-1:0]  lim_v;
   logic     [NWIN-1:0][31:0]       wlim;
   logic     [NWIN-1:0][31:0]       wcnt;
   logic     [CNT_W-1:0]            wfield;
   logic     [31:0]                 rd_word;
   logic                            unused_wd;

   assign wfield    = bus_wdata[FLD_LSB +: CNT_W];
   assign unused_wd = ^bus_wdata;

   mpt_decode #(
      .NWIN   (NWIN),
      .ADDR_W (ADDR_W)
   ) u_dec (
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .cmd_o    (cmd_v),
      .rd_win   (rd_win),
      .rd_reg   (rd_reg)
   );

   for (genvar w = 0; w < NWIN; w++) begin : g_tmr
      localparam logic [CNT_W-1:0] RST_L =
         (w == NCPU) ? CNT_W'(MST_RST_LIM) : CNT_W'(PCPU_RST_LIM);

      mpt_counter #(
         .CNT_W   (CNT_W),
         .RST_LIM (RST_L)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_en (tick_en),
         .cmd     (cmd_v[w]),
         .wfield  (wfield),
         .wrun    (bus_wdata[0]),
         .flag    (flag_v[w]),
         .cnt     (cnt_v[w]),
         .lim     (lim_v[w]),
         .run     (run_v[w])
      );

      assign wlim[w] = (32'(flag_v[w]) << 31) | (32'(lim_v[w]) << FLD_LSB);
      assign wcnt[w] = (32'(flag_v[w]) << 31) | (32'(cnt_v[w]) << FLD_LSB);
   end

   // interrupt routing: private lines and broadcast master line
   assign irq_cpu_l14   = flag_v[NCPU-1:0];
   assign irq_bcast_l10 = {NCPU{flag_v[NCPU]}};

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NWIN; w++) begin
         if (rd_win == WIN_W'(w)) begin
            case (rd_reg)
               REG_LIM: rd_word = wlim[w];
               REG_CNT: rd_word = wcnt[w];
               REG_CTL: rd_word = {31'b0, run_v[w]};
               default: rd_word = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 bus_rdata <= '0;
      else if (bus_sel && !bus_wr) bus_rdata <= rd_word;
   end

endmodule

// File: rtl/mpt_timer_bank_chk.sv
module mpt_timer_bank_chk #(
   parameter int NCPU   = 4,
   parameter int CNT_W  = 21,
   localparam int NWIN  = NCPU + 1,
   localparam int ADDR_W = $clog2(NWIN * 16)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tick_en,
   input logic                       bus_sel,
   input logic                       bus_wr,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [NWIN-1:0]            flag_v,
   input logic [NWIN-1:0]            run_v,
   input logic [NWIN-1:0][CNT_W-1:0] cnt_v,
   input logic [NWIN-1:0][CNT_W-1:0] lim_v,
   input logic [NCPU-1:0]            irq_cpu_l14
);

   for (genvar w = 0; w < NWIN; w++) begin : g_w
      // R1: counter field never holds zero
      p_cnt_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_v[w] != '0);

      // R1: reaching the limit reloads 1 and raises the flag
      p_hit_wraps_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_en && run_v[w] && !bus_sel && lim_v[w] != '0 &&
          CNT_W'(cnt_v[w] + 1'b1) == lim_v[w])
         |=> (cnt_v[w] == CNT_W'(1) && flag_v[w]));

      // R8: zero limit never raises the flag
      p_free_noirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (lim_v[w] == '0 && !flag_v[w] && !bus_sel) |=> !flag_v[w]);

      // R9: no advance without an enabled tick
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!bus_sel && !(tick_en && run_v[w])) |=> $stable(cnt_v[w]));

      // R7: limit read acknowledges the flag
      p_lim_rd_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && !bus_wr && bus_addr == ADDR_W'(w * 16) && !tick_en)
         |=> !flag_v[w]);
   end

   for (genvar i = 0; i < NCPU; i++) begin : g_irq
      // R5: a private interrupt only rises after a tick
      p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_cpu_l14[i]) |-> $past(tick_en));
   end

endmodule

bind mpt_timer_bank mpt_timer_bank_chk #(
   .NCPU  (NCPU),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .flag_v      (flag_v),
   .run_v       (run_v),
   .cnt_v       (cnt_v),
   .lim_v       (lim_v),
   .irq_cpu_l14 (irq_cpu_l14)
);

// File: tb/mpt_timer_bank_test.sv
module mpt_timer_bank_test;
   localparam int NC   = 2;
   localparam int CW   = 8;
   localparam int LSB  = 10;
   localparam int RSTL = 20;
   localparam int AW   = 6;    // clog2(3*16)
   localparam int MST  = NC * 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NC-1:0] irq14, irq10;

   logic        dsel = 1'b0;
   logic [6:0]  daddr = '0;
   logic [31:0] drdata;
   logic [3:0]  dirq14, dirq10;

   int nchk = 0;
   int nfail = 0;
   logic [31:0] v;

   always #10 clk = ~clk;   // 50 MHz

   mpt_timer_bank #(
      .NCPU(NC), .CNT_W(CW), .FLD_LSB(LSB), .PCPU_RST_LIM(RSTL), .MST_RST_LIM(0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_sel(sel), .bus_wr(wr),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .irq_cpu_l14(irq14), .irq_bcast_l10(irq10)
   );

   mpt_timer_bank u_dflt (
      .clk(clk), .rst_n(rst_n), .tick_en(1'b0), .bus_sel(dsel), .bus_wr(1'b0),
      .bus_addr(daddr), .bus_wdata(32'h0), .bus_rdata(drdata),
      .irq_cpu_l14(dirq14), .irq_bcast_l10(dirq10)
   );

   function automatic logic [31:0] word(input logic f, input int fld);
      return ({f, 31'b0}) | (32'(fld) << LSB);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bwr(input int a, input logic [31:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk); sel = 1'b0; wr = 1'b0;
   endtask

   task automatic brd(input int a, output logic [31:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = AW'(a);
      @(negedge clk); sel = 1'b0; d = rdata;
   endtask

   task automatic drd(input int a, output logic [31:0] d);
      @(negedge clk); dsel = 1'b1; daddr = 7'(a);
      @(negedge clk); dsel = 1'b0; d = drdata;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk); tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6 reset state
      brd(0, v);        chk("R6 cpu0 limit", v, word(0, RSTL));
      brd(16, v);       chk("R6 cpu1 limit", v, word(0, RSTL));
      brd(MST, v);      chk("R6 master limit", v, word(0, 0));
      brd(4, v);        chk("R6 cpu0 count", v, word(0, 1));
      brd(12, v);       chk("R6 cpu0 run bit", v, 32'h1);
      chk("R6 irq idle", {30'b0, irq14}, 32'h0);
      drd(0, v);        chk("R6 default cpu0 limit", v, 32'h009C4000);
      drd(48, v);       chk("R6 default cpu3 limit", v, 32'h009C4000);
      drd(64, v);       chk("R6 default master limit", v, 32'h0);

      // R3 / R2 / R1 basic period
      bwr(0, 32'h8000_03FF | (32'd5 << LSB));
      brd(0, v);        chk("R2 limit word low bits zero", v, word(0, 5));
      brd(4, v);        chk("R3 count restarts at 1", v, word(0, 1));
      ticks(3);
      brd(4, v);        chk("R1 count after 3 ticks", v, word(0, 4));
      chk("R5 no irq before limit", {30'b0, irq14}, 32'h0);
      ticks(1);
      chk("R5 cpu0 irq only", {30'b0, irq14}, 32'h1);
      chk("R5 master line quiet", {30'b0, irq10}, 32'h0);
      brd(4, v);        chk("R1 wrap to 1 with flag", v, word(1, 1));
      brd(4, v);        chk("R7 count read keeps flag", v, word(1, 1));
      brd(0, v);        chk("R7 limit read returns flag", v, word(1, 5));
      chk("R7 irq dropped after limit read", {30'b0, irq14}, 32'h0);
      brd(4, v);        chk("R7 flag cleared", v, word(0, 1));

      // R1 period sweep
      for (int l = 2; l <= 12; l++) begin
         bwr(0, word(0, l));
         ticks(l - 2);
         brd(4, v);     chk("R1 sweep one before limit", v, word(0, l - 1));
         ticks(1);
         brd(4, v);     chk("R1 sweep wrap", v, word(1, 1));
         brd(0, v);     chk("R1 sweep limit/ack", v, word(1, l));
      end

      // R4 limit write without restart
      bwr(0, word(0, 10));
      ticks(3);
      bwr(8, word(0, 6));
      brd(4, v);        chk("R4 count kept", v, word(0, 4));
      brd(0, v);        chk("R4 new limit", v, word(0, 6));
      ticks(1);
      brd(4, v);        chk("R4 runs on", v, word(0, 5));
      ticks(1);
      brd(4, v);        chk("R4 hits new limit", v, word(1, 1));
      bwr(8, word(0, 9));
      brd(4, v);        chk("R4 flag kept", v, word(1, 1));
      brd(0, v);        chk("R4 limit updated", v, word(1, 9));
      brd(8, v);        chk("R10 offset 8 reads zero", v, 32'h0);

      // R9 run bit gating
      bwr(16, word(0, 0));
      bwr(28, 32'h0);
      ticks(5);
      brd(20, v);       chk("R9 stopped timer holds", v, word(0, 1));
      brd(28, v);       chk("R9 run bit reads 0", v, 32'h0);
      bwr(28, 32'h1);
      ticks(5);
      brd(20, v);       chk("R9 resumed count", v, word(0, 6));

      // R8 free-running wrap at max
      ticks(249);
      brd(20, v);       chk("R8 count at max", v, word(0, 255));
      ticks(1);
      brd(20, v);       chk("R8 wrap to 1 without flag", v, word(0, 1));
      chk("R8 no cpu1 irq", 32'(irq14[1]), 32'h0);

      // R5 master broadcast
      bwr(MST, word(0, 4));
      ticks(2);
      chk("R5 master quiet", {30'b0, irq10}, 32'h0);
      ticks(1);
      chk("R5 master to all cpus", {30'b0, irq10}, 32'h3);
      chk("R5 master not on private line", 32'(irq14[1]), 32'h0);
      brd(MST + 4, v);  chk("R10 master count window", v, word(1, 1));
      brd(MST, v);      chk("R7 master ack", v, word(1, 4));
      chk("R7 master irq dropped", {30'b0, irq10}, 32'h0);

      // R3 flag clear by restart write
      bwr(0, word(0, 3));
      ticks(2);
      chk("R3 cpu0 irq raised", 32'(irq14[0]), 32'h1);
      bwr(0, word(0, 7));
      chk("R3 restart write drops irq", 32'(irq14[0]), 32'h0);
      brd(4, v);        chk("R3 restart count", v, word(0, 1));

      // R10 unmapped window
      bwr(48, word(0, 2));
      brd(48, v);       chk("R10 unmapped window reads zero", v, 32'h0);
      brd(0, v);        chk("R10 unmapped write ignored", v, word(0, 7));

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule